// File: doc/BRIEF.md
# Cache Way Inversion Balancer

This block controls a set-associative tag and data array. It keeps a chosen share of all its entries in an inverted, invalid state. The goal is to even out how long each storage bit spends at 0 and at 1. Inverting an entry destroys its contents, so an entry is always invalidated as it is complemented. A complemented entry can never produce a hit. The ways picked for inversion are the non-inverted ways with the oldest LRU rank in their set, because those lines are the least likely to be used again. The array is write-through, so an evicted or inverted line is simply dropped.

A single request port carries lookups and fills. A lookup answers one cycle later with a hit flag and the stored data. A fill writes a line without producing a response. A background balancer acts on every cycle without a request. It inverts or restores one entry per cycle until the number of inverted entries equals the current goal. It serves a set whose inverted way was just refilled before anything else, and otherwise visits the sets in rotation.

In basic mode the goal is half of all entries. In adaptive mode the goal rises to a higher percentage while a saturating miss counter stays below a threshold. It falls back to half once the counter reaches that threshold.

Top module: `cache_inv_balancer`

## Requirements
- R1: After reset no entry is valid or inverted: `inv_total` is 0, `rsp_valid` and `rsp_hit` are 0, and the first lookup misses.
- R2: With `adapt_en`=0, idle cycles bring `inv_total` to ENTRIES/2 and hold it there. The balancer changes at most one entry per cycle, does nothing in a cycle that carries a request, and never leaves a set without a non-inverted way.
- R3: An inverted entry is always invalid and never hits. The balancer inverts the non-inverted way with the highest LRU rank (rank WAYS-1 is least recent), even if that way holds a valid line.
- R4: A lookup (`req_valid`=1, `req_fill`=0) gives `rsp_valid`=1 on the next cycle, with `rsp_hit` and, on a hit, `rsp_data` equal to the last data filled for that set and tag. A fill (`req_fill`=1) gives no response.
- R5: A fill into an inverted way stores the true data and clears that way's inverted flag. The next balancing action is taken in the same set, and it never picks the line that was just filled.
- R6: A fill whose tag is already present rewrites that way in place. Otherwise the fill replaces the way of rank WAYS-1. Lookup hits and fills make the touched way rank 0.
- R7: With `adapt_en`=1 and the miss counter below THRESH, the goal is ENTRIES*HI_PCT/100, and idle cycles bring `inv_total` to that value.
- R8: The miss counter rises by one on each lookup miss and falls by one on each lookup hit, saturating at both ends. While it is at or above THRESH, the adaptive goal is ENTRIES/2, and surplus inverted entries are restored as invalid entries.
- R9: With `adapt_en`=0 the goal is ENTRIES/2 whatever the miss counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| adapt_en | input | 1 | 1 selects the adaptive inversion goal |
| req_valid | input | 1 | Request present this cycle |
| req_fill | input | 1 | 1 = fill, 0 = lookup |
| req_set | input | IW | Set index of the request |
| req_tag | input | TAG_W | Tag of the request |
| req_wdata | input | DATA_W | Fill data |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | DATA_W | Data of the hit line |
| inv_total | output | CW | Number of entries currently inverted |

## Verification
The bench builds the block with 4 sets of 4 ways, 8-bit tags, 16-bit data, a 60% high goal, and a 3-bit miss counter with a threshold of 4. This gives goals of 8 and 9 out of 16 entries. The small sets let a handful of back-to-back fills walk a whole set through its LRU order, push refilled lines back onto the inversion candidates, and evict a valid line. The low threshold lets four misses swing the adaptive goal down and four hits swing it back up within a few dozen cycles.

// File: rtl/cii_pkg.sv
// Shared types for the cache way inversion balancer.
package cii_pkg;
    // Action taken by the background balancer in one cycle.
    typedef enum logic [1:0] {
        ENG_HOLD    = 2'd0,
        ENG_INVERT  = 2'd1,
        ENG_RESTORE = 2'd2
    } eng_act_e;
endpackage

// File: rtl/cii_pick.sv
// Finds, among candidate ways, the one of highest (FIND_MAX=1) or lowest
// LRU rank. Purely combinational. Assumes ranks within a set are distinct.
module cii_pick #(
    parameter int WAYS     = 4,
    parameter bit FIND_MAX = 1'b1,
    parameter int WW       = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WW-1:0] rank,
    input  logic [WAYS-1:0]         cand,
    output logic                    found,
    output logic [WW-1:0]           way
);
    logic [WW-1:0] best;

    if (FIND_MAX) begin : g_max
        // Scan for the candidate with the oldest rank.
        always_comb begin
            found = 1'b0;
            way   = '0;
            best  = '0;
            for (int w = 0; w < WAYS; w++) begin
                if (cand[w] && (!found || rank[w] > best)) begin
                    found = 1'b1;
                    way   = WW'(w);
                    best  = rank[w];
                end
            end
        end
    end else begin : g_min
        // Scan for the candidate with the most recent rank.
        always_comb begin
            found = 1'b0;
            way   = '0;
            best  = '0;
            for (int w = 0; w < WAYS; w++) begin
                if (cand[w] && (!found || rank[w] < best)) begin
                    found = 1'b1;
                    way   = WW'(w);
                    best  = rank[w];
                end
            end
        end
    end
endmodule

// File: rtl/cii_lru.sv
// Per-set true-LRU ranks: rank 0 is most recent, WAYS-1 least recent.
// Two combinational read ports, one touch port. Reset gives way w rank w.
module cii_lru #(
    parameter int SETS = 64,
    parameter int WAYS = 4,
    parameter int IW   = $clog2(SETS),
    parameter int WW   = $clog2(WAYS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    touch_en,
    input  logic [IW-1:0]           touch_set,
    input  logic [WW-1:0]           touch_way,
    input  logic [IW-1:0]           rd_a_set,
    output logic [WAYS-1:0][WW-1:0] rd_a_rank,
    input  logic [IW-1:0]           rd_b_set,
    output logic [WAYS-1:0][WW-1:0] rd_b_rank
);
    logic [WAYS-1:0][WW-1:0] rank_q [SETS];
    logic [WW-1:0]           touched_rank;

    assign touched_rank = rank_q[touch_set][touch_way];
    assign rd_a_rank    = rank_q[rd_a_set];
    assign rd_b_rank    = rank_q[rd_b_set];

    // Move the touched way to rank 0 and age the ways that were newer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    rank_q[s][w] <= WW'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WW'(w) == touch_way)
                    rank_q[touch_set][w] <= '0;
                else if (rank_q[touch_set][w] < touched_rank)
                    rank_q[touch_set][w] <= rank_q[touch_set][w] + WW'(1);
            end
        end
    end
endmodule

// File: rtl/cii_goal.sv
// Saturating miss counter and inversion goal selection.
// Assumes ENTRIES*HI_PCT/100 leaves at least one way per set free.
module cii_goal #(
    parameter int ENTRIES = 256,
    parameter int HI_PCT  = 60,
    parameter int CNT_W   = 6,
    parameter int THRESH  = 32,
    parameter int CW      = $clog2(ENTRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adapt_en,
    input  logic          lk_valid,
    input  logic          lk_hit,
    output logic [CW-1:0] goal
);
    localparam int GOAL_BASE = ENTRIES / 2;
    localparam int GOAL_HI   = (ENTRIES * HI_PCT) / 100;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] miss_q;

    // Count misses up and hits down, clamped at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            miss_q <= '0;
        else if (lk_valid && !lk_hit && miss_q != CNT_MAX)
            miss_q <= miss_q + CNT_W'(1);
        else if (lk_valid && lk_hit && miss_q != '0)
            miss_q <= miss_q - CNT_W'(1);
    end

    // High goal only in adaptive mode with few recent misses.
    always_comb begin
        if (adapt_en && miss_q < CNT_W'(THRESH))
            goal = CW'(GOAL_HI);
        else
            goal = CW'(GOAL_BASE);
    end
endmodule

// File: rtl/cache_inv_balancer.sv
// Set-associative tag/data array that keeps a goal count of entries
// inverted (complemented and invalid). Lookups and fills share one port;
// balancing runs one entry per request-free cycle. Assumes SETS and WAYS
// are powers of two, WAYS >= 2, write-through data (no writeback).
module cache_inv_balancer #(
    parameter int SETS    = 64,
    parameter int WAYS    = 4,
    parameter int TAG_W   = 20,
    parameter int DATA_W  = 32,
    parameter int HI_PCT  = 60,
    parameter int CNT_W   = 6,
    parameter int THRESH  = 32,
    localparam int ENTRIES = SETS * WAYS,
    localparam int IW      = $clog2(SETS),
    localparam int WW      = $clog2(WAYS),
    localparam int CW      = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adapt_en,
    input  logic              req_valid,
    input  logic              req_fill,
    input  logic [IW-1:0]     req_set,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CW-1:0]     inv_total
);
    import cii_pkg::*;

    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [DATA_W-1:0] data_q [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   inv_q   [SETS];
    logic [SETS-1:0]   pend_q;
    logic [IW-1:0]     ptr_q;
    logic [CW-1:0]     total_q;

    logic [WAYS-1:0]         hit_vec;
    logic                    hit_any;
    logic [WW-1:0]           hit_way;
    logic [WAYS-1:0][WW-1:0] req_rank, eng_rank;
    logic                    vict_found;
    logic [WW-1:0]           vict_way, fill_way;
    logic                    fill_into_inv;
    logic                    lk_valid;
    logic [CW-1:0]           goal;

    logic                    pend_any;
    logic [IW-1:0]           pend_idx, eng_set;
    logic                    inv_found, rst_found, room;
    logic [WW-1:0]           inv_way, rst_way;
    int                      free_cnt;
    eng_act_e                eng_act;
    logic                    ptr_step, pend_clr;

    logic [ENTRIES-1:0]      valid_flat, inv_flat;

    assign lk_valid  = req_valid && !req_fill;
    assign inv_total = total_q;

    // Tag compare for the requested set; inverted entries never match.
    always_comb begin
        hit_any = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = valid_q[req_set][w] && !inv_q[req_set][w] &&
                         tag_q[req_set][w] == req_tag;
            if (hit_vec[w]) begin
                hit_any = 1'b1;
                hit_way = WW'(w);
            end
        end
    end

    cii_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (req_valid && (req_fill || hit_any)),
        .touch_set (req_set),
        .touch_way (req_fill ? fill_way : hit_way),
        .rd_a_set  (req_set),
        .rd_a_rank (req_rank),
        .rd_b_set  (eng_set),
        .rd_b_rank (eng_rank)
    );

    cii_pick #(.WAYS(WAYS), .FIND_MAX(1'b1)) u_pick_victim (
        .rank  (req_rank),
        .cand  ({WAYS{1'b1}}),
        .found (vict_found),
        .way   (vict_way)
    );

    assign fill_way      = hit_any ? hit_way : vict_way;
    assign fill_into_inv = req_valid && req_fill && inv_q[req_set][fill_way];

    cii_goal #(.ENTRIES(ENTRIES), .HI_PCT(HI_PCT), .CNT_W(CNT_W),
               .THRESH(THRESH)) u_goal (
        .clk      (clk),
        .rst_n    (rst_n),
        .adapt_en (adapt_en),
        .lk_valid (lk_valid),
        .lk_hit   (hit_any),
        .goal     (goal)
    );

    // Lowest-numbered set waiting for a replacement inversion.
    always_comb begin
        pend_any = |pend_q;
        pend_idx = '0;
        for (int s = SETS - 1; s >= 0; s--)
            if (pend_q[s]) pend_idx = IW'(s);
    end

    assign eng_set = (pend_any && total_q < goal) ? pend_idx : ptr_q;

    cii_pick #(.WAYS(WAYS), .FIND_MAX(1'b1)) u_pick_inv (
        .rank  (eng_rank),
        .cand  (~inv_q[eng_set]),
        .found (inv_found),
        .way   (inv_way)
    );

    cii_pick #(.WAYS(WAYS), .FIND_MAX(1'b0)) u_pick_rst (
        .rank  (eng_rank),
        .cand  (inv_q[eng_set]),
        .found (rst_found),
        .way   (rst_way)
    );

    // Inverting is allowed only if the set keeps a non-inverted way.
    always_comb begin
        free_cnt = 0;
        for (int w = 0; w < WAYS; w++)
            if (!inv_q[eng_set][w]) free_cnt++;
        room = free_cnt >= 2;
    end

    // Choose this cycle's balancing action and pointer movement.
    always_comb begin
        eng_act  = ENG_HOLD;
        ptr_step = 1'b0;
        pend_clr = 1'b0;
        if (!req_valid) begin
            if (total_q < goal) begin
                if (inv_found && room) eng_act = ENG_INVERT;
                if (pend_any) pend_clr = 1'b1;
                else          ptr_step = 1'b1;
            end else if (total_q > goal) begin
                if (rst_found) eng_act = ENG_RESTORE;
                ptr_step = 1'b1;
            end
        end
    end

    // Valid/inverted flags, pending sets, pointer and inverted count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                inv_q[s]   <= '0;
            end
            pend_q  <= '0;
            ptr_q   <= '0;
            total_q <= '0;
        end else if (req_valid && req_fill) begin
            valid_q[req_set][fill_way] <= 1'b1;
            inv_q[req_set][fill_way]   <= 1'b0;
            if (fill_into_inv) begin
                pend_q[req_set] <= 1'b1;
                total_q         <= total_q - CW'(1);
            end
        end else begin
            if (pend_clr) pend_q[eng_set] <= 1'b0;
            if (ptr_step) ptr_q <= ptr_q + IW'(1);
            if (eng_act == ENG_INVERT) begin
                valid_q[eng_set][inv_way] <= 1'b0;
                inv_q[eng_set][inv_way]   <= 1'b1;
                total_q                   <= total_q + CW'(1);
            end else if (eng_act == ENG_RESTORE) begin
                inv_q[eng_set][rst_way] <= 1'b0;
                total_q                 <= total_q - CW'(1);
            end
        end
    end

    // Array contents: fills write true data, balancing complements in place.
    always_ff @(posedge clk) begin
        if (req_valid && req_fill) begin
            tag_q[req_set][fill_way]  <= req_tag;
            data_q[req_set][fill_way] <= req_wdata;
        end else if (eng_act == ENG_INVERT) begin
            tag_q[eng_set][inv_way]  <= ~tag_q[eng_set][inv_way];
            data_q[eng_set][inv_way] <= ~data_q[eng_set][inv_way];
        end else if (eng_act == ENG_RESTORE) begin
            tag_q[eng_set][rst_way]  <= ~tag_q[eng_set][rst_way];
            data_q[eng_set][rst_way] <= ~data_q[eng_set][rst_way];
        end
    end

    // Registered lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && hit_any;
            rsp_data  <= (lk_valid && hit_any) ? data_q[req_set][hit_way] : '0;
        end
    end

    // Flattened flag views for the bound checker.
    always_comb begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                valid_flat[s*WAYS + w] = valid_q[s][w];
                inv_flat[s*WAYS + w]   = inv_q[s][w];
            end
    end

    logic unused_ok;
    assign unused_ok = vict_found;
endmodule

// File: rtl/cii_checker.sv
// Protocol and invariant checks for cache_inv_balancer, bound to the top.
module cii_checker #(
    parameter int SETS = 64,
    parameter int WAYS = 4,
    parameter int CW   = $clog2(SETS * WAYS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_fill,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [CW-1:0]        inv_total,
    input logic [SETS*WAYS-1:0] valid_flat,
    input logic [SETS*WAYS-1:0] inv_flat
);
    AST_INV_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_flat & valid_flat) == '0); // R3
    AST_LOOKUP_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_fill) |=> rsp_valid); // R4
    AST_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_fill) |=> !rsp_valid); // R4
    AST_HIT_HAS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid); // R4
    AST_TOTAL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        32'(inv_total) == $countones(inv_flat)); // R2
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_total == $past(inv_total)) || (inv_total == $past(inv_total) + 1'b1) ||
        (inv_total + 1'b1 == $past(inv_total))); // R2

    for (genvar s = 0; s < SETS; s++) begin : g_set
        AST_SET_KEEPS_WAY: assert property (@(posedge clk) disable iff (!rst_n)
            !(&inv_flat[s*WAYS +: WAYS])); // R2
    end
endmodule

bind cache_inv_balancer cii_checker #(.SETS(SETS), .WAYS(WAYS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_fill   (req_fill),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .inv_total  (inv_total),
    .valid_flat (valid_flat),
    .inv_flat   (inv_flat)
);

// File: tb/cache_inv_balancer_tb.sv
`timescale 1ns/1ps
module cache_inv_balancer_tb;
    localparam int SETS = 4, WAYS = 4, TAG_W = 8, DATA_W = 16;
    localparam int HI_PCT = 60, CNT_W = 3, THRESH = 4;
    localparam int CW = $clog2(SETS * WAYS + 1);
    localparam int GOAL_BASE = 8, GOAL_HI = 9;

    logic clk = 1'b0, rst_n = 1'b0, adapt_en = 1'b0;
    logic req_valid = 1'b0, req_fill = 1'b0;
    logic [1:0] req_set = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic rsp_valid, rsp_hit;
    logic [DATA_W-1:0] rsp_data;
    logic [CW-1:0] inv_total;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cache_inv_balancer #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W),
        .HI_PCT(HI_PCT), .CNT_W(CNT_W), .THRESH(THRESH)) u_dut (
        .clk(clk), .rst_n(rst_n), .adapt_en(adapt_en), .req_valid(req_valid),
        .req_fill(req_fill), .req_set(req_set), .req_tag(req_tag),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_data(rsp_data), .inv_total(inv_total));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All request tasks start and end just after a falling edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lookup(input int s, input int tag, input bit exp_hit,
                          input int exp_data, input string req);
        req_valid = 1'b1; req_fill = 1'b0; req_set = 2'(s); req_tag = 8'(tag);
        @(negedge clk);
        chk({req, " rsp_valid"}, int'(rsp_valid), 1);
        chk({req, " rsp_hit"}, int'(rsp_hit), int'(exp_hit));
        if (exp_hit) chk({req, " rsp_data"}, int'(rsp_data), exp_data);
        req_valid = 1'b0;
    endtask

    task automatic fill(input int s, input int tag, input int data, input string req);
        req_valid = 1'b1; req_fill = 1'b1; req_set = 2'(s);
        req_tag = 8'(tag); req_wdata = 16'(data);
        @(negedge clk);
        chk({req, " fill gives no rsp"}, int'(rsp_valid), 0);
        req_valid = 1'b0; req_fill = 1'b0;
    endtask

    // R1: reset state and first lookup.
    task automatic t_reset;
        idle(3);
        rst_n = 1'b1;
        chk("R1 inv_total", int'(inv_total), 0);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 rsp_hit", int'(rsp_hit), 0);
        lookup(0, 8'h05, 1'b0, 0, "R1 empty lookup");
    endtask

    // R2: basic-mode convergence to half the entries and holding there.
    task automatic t_converge;
        idle(20);
        chk("R2 converged", int'(inv_total), GOAL_BASE);
        idle(10);
        chk("R2 held", int'(inv_total), GOAL_BASE);
    endtask

    // R4/R5/R6: fill, hit, miss, rewrite in place, refill of an inverted way.
    task automatic t_fill_hit;
        fill(0, 8'h11, 16'hABCD, "R5 fill into inverted way");
        chk("R5 count drops on fill", int'(inv_total), GOAL_BASE - 1);
        lookup(0, 8'h11, 1'b1, 16'hABCD, "R4 hit");
        lookup(0, 8'h22, 1'b0, 0, "R4 miss");
        fill(0, 8'h11, 16'h5555, "R6 rewrite");
        lookup(0, 8'h11, 1'b1, 16'h5555, "R6 rewrite in place");
        idle(10);
        chk("R5 count restored", int'(inv_total), GOAL_BASE);
        lookup(0, 8'h11, 1'b0 ^ 1'b1, 16'h5555, "R5 new line not reinverted");
    endtask

    // R3/R6: LRU-near line inverted, LRU victim on fill.
    task automatic t_lru;
        fill(1, 8'h31, 16'h0A31, "R6 fill A");
        fill(1, 8'h32, 16'h0A32, "R6 fill B");
        fill(1, 8'h33, 16'h0A33, "R6 fill C");
        fill(1, 8'h34, 16'h0A34, "R6 fill D");
        lookup(1, 8'h34, 1'b1, 16'h0A34, "R4 hit D");
        idle(10);
        chk("R2 after fills", int'(inv_total), GOAL_BASE);
        lookup(1, 8'h31, 1'b0, 0, "R3 oldest line inverted");
        lookup(1, 8'h34, 1'b1, 16'h0A34, "R3 recent D kept");
        lookup(1, 8'h32, 1'b1, 16'h0A32, "R3 recent B kept");
        lookup(1, 8'h33, 1'b1, 16'h0A33, "R3 recent C kept");
        fill(1, 8'h35, 16'h0A35, "R6 fill E");
        fill(1, 8'h36, 16'h0A36, "R6 fill F");
        lookup(1, 8'h34, 1'b0, 0, "R6 LRU line D evicted");
        lookup(1, 8'h32, 1'b1, 16'h0A32, "R6 B kept");
        lookup(1, 8'h36, 1'b1, 16'h0A36, "R6 F present");
        idle(10);
        chk("R2 after evictions", int'(inv_total), GOAL_BASE);
    endtask

    // R7/R8/R9: adaptive goal follows the miss counter; basic ignores it.
    task automatic t_adaptive;
        adapt_en = 1'b1;
        idle(20);
        chk("R7 high goal", int'(inv_total), GOAL_HI);
        for (int i = 0; i < 4; i++)
            lookup(2, 8'h90 + i, 1'b0, 0, "R8 miss");
        idle(20);
        chk("R8 fallback goal", int'(inv_total), GOAL_BASE);
        for (int i = 0; i < 4; i++)
            lookup(0, 8'h11, 1'b1, 16'h5555, "R8 hit");
        idle(20);
        chk("R8 counter drained, high goal", int'(inv_total), GOAL_HI);
        adapt_en = 1'b0;
        idle(20);
        chk("R9 basic goal with low counter", int'(inv_total), GOAL_BASE);
    endtask

    initial begin
        t_reset();
        t_converge();
        t_fill_hit();
        t_lru();
        t_adaptive();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule